// File: doc/BRIEF.md
# Stereo Pilot Phase Tracker

This block is a sampled-data, second-order phase-locked loop that follows the 19 kHz pilot tone carried in a demodulated broadcast FM baseband signal. Signed samples arrive with a strobe at a fixed decimated rate of 240 ksps. Each accepted sample is multiplied by the cosine of the locally held phase. The product is the phase-error sample. It drives a proportional-plus-integral filter, and the filter output moves a 32-bit phase accumulator away from its nominal 19 kHz step.

The same locked phase word gives three cosine references. The first is at the pilot phase. The other two are at twice and three times that phase, for coherent demodulation of the 38 kHz and 57 kHz subcarriers. All three come from one quarter-wave table that is computed when the design elaborates. The default gains give a damping factor near 0.707 and a noise bandwidth near 10 Hz at 240 ksps. Wider-band gain settings can be chosen through parameters.

Top module: `pilot_pll_top`

## Requirements
- R1: A synchronous `rst` clears the phase word, the integrator, the registered error and `out_valid`. After reset, with zero input, the first accepted sample advances the phase by exactly the nominal step.
- R2: The nominal step is floor(2^32 * CENTER_HZ / SAMPLE_HZ), which is 340018244 at the defaults. When the filter output is zero, an accepted sample advances the phase word by exactly this step, modulo 2^32.
- R3: A cycle with `in_valid` low changes neither the phase word, nor the registered error, nor the integrator, whatever `in_sample` holds.
- R4: `cos1_o` is the table cosine of the phase word. The index is phase bits [31:22]. The value is round(32767 * cos(2*pi*(index+0.5)/1024)), built from a 256-entry quarter table by sign and index mirroring.
- R5: `cos2_o` and `cos3_o` are the table cosines of (2 * phase) mod 2^32 and (3 * phase) mod 2^32.
- R6: For an accepted sample, `err_o` becomes (in_sample * cos1_o) >>> 15, using the cosine shown before the clock edge. The shift is arithmetic, so it floors.
- R7: The filter output is (err * KP_MUL) >>> KP_SHIFT plus (acc + err * KI_MUL) >>> KI_SHIFT, where acc is the integrator state. The integrator then takes acc + err * KI_MUL. The phase advances by step plus the filter output.
- R8: For a pilot tone 3 Hz above or below 19 kHz, the loop locks. In the bench gain setting, after settling, the mean phase error stays near zero and the phase word tracks the input phase to within 0.05 rad.
- R9: `out_valid` is high for exactly the cycle after each cycle with `in_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Strobe marking an accepted sample |
| in_sample | input | 16 | Signed baseband sample |
| out_valid | output | 1 | Marks an updated error and phase |
| phase_o | output | 32 | Tracked phase word, 2^32 per turn |
| err_o | output | 16 | Signed phase-error sample |
| cos1_o | output | 16 | Cosine of the tracked phase |
| cos2_o | output | 16 | Cosine of twice the tracked phase |
| cos3_o | output | 16 | Cosine of three times the tracked phase |

## Verification
The assertions check on every cycle the rules that hold cycle by cycle:
- The reset state.
- The hold of the phase, the error and the integrator when no sample is strobed.
- The exact nominal step when the filter output is zero.
- The one-cycle valid pulse.

The table values, the harmonic lookups and the error and filter arithmetic are checked by the bench. It uses an independent arithmetic model that it walks alongside the design. Lock to an offset pilot tone can only be shown by the bench's long tone scenarios. These measure the mean error and the phase tracking after settling.

// File: rtl/pll_pkg.sv
package pll_pkg;
  localparam int PH_W  = 32;
  localparam int SMP_W = 16;

  typedef logic [PH_W-1:0]         phase_t;
  typedef logic signed [SMP_W-1:0] sample_t;

  // Phase increment per sample for a given tone and sample rate
  function automatic phase_t nominal_step(longint unsigned f_hz, longint unsigned fs_hz);
    longint unsigned full;
    full = (64'd1 << PH_W) * f_hz / fs_hz;
    return phase_t'(full);
  endfunction

  // Multiplier phase detector, cosine scaled to 2^(SMP_W-1)
  function automatic sample_t pd_product(sample_t x, sample_t c);
    logic signed [2*SMP_W-1:0] p;
    p = x * c;
    return sample_t'(p >>> (SMP_W - 1));
  endfunction
endpackage

// File: rtl/pll_cos_lut.sv
module pll_cos_lut import pll_pkg::*; #(
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] idx_i,
  output sample_t          cos_o
);
  localparam int Q_W = IDX_W - 2;
  localparam int Q_N = 1 << Q_W;
  localparam int AMP = (1 << (SMP_W - 1)) - 1;
  localparam real TWO_PI = 6.283185307179586;

  sample_t qtab [Q_N];

  // Quarter table sampled at half-step offsets so mirroring is exact
  for (genvar j = 0; j < Q_N; j++) begin : g_tab
    localparam real ANG = TWO_PI * (real'(j) + 0.5) / real'(1 << IDX_W);
    localparam int  VAL = $rtoi(real'(AMP) * $cos(ANG) + 0.5);
    assign qtab[j] = sample_t'(VAL);
  end

  logic [1:0]     quad;
  logic [Q_W-1:0] off;
  assign quad = idx_i[IDX_W-1 -: 2];
  assign off  = idx_i[Q_W-1:0];

  always_comb begin
    unique case (quad)
      2'd0:    cos_o = qtab[off];
      2'd1:    cos_o = -qtab[~off];
      2'd2:    cos_o = -qtab[off];
      default: cos_o = qtab[~off];
    endcase
  end
endmodule

// File: rtl/pll_phase_det.sv
module pll_phase_det import pll_pkg::*; (
  input  sample_t x_i,
  input  sample_t cos_i,
  output sample_t err_o
);
  assign err_o = pd_product(x_i, cos_i);
endmodule

// File: rtl/pll_loop_filter.sv
module pll_loop_filter import pll_pkg::*; #(
  parameter int KP_MUL   = 37,
  parameter int KP_SHIFT = 2,
  parameter int KI_MUL   = 135,
  parameter int KI_SHIFT = 18,
  parameter int ACC_W    = 48
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en_i,
  input  sample_t                err_i,
  output logic signed [PH_W-1:0] ctrl_o
);
  logic signed [ACC_W-1:0] acc_q, acc_next, err_x, kp_x, ki_x, p_term, i_term;

  assign err_x    = ACC_W'(err_i);
  assign kp_x     = ACC_W'(KP_MUL);
  assign ki_x     = ACC_W'(KI_MUL);
  assign p_term   = (err_x * kp_x) >>> KP_SHIFT;
  assign acc_next = acc_q + err_x * ki_x;
  assign i_term   = acc_next >>> KI_SHIFT;
  assign ctrl_o   = PH_W'(p_term + i_term);

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (en_i) acc_q <= acc_next;
  end

  // R7: integrator only moves on an accepted sample
  assert_integ_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(acc_q));
endmodule

// File: rtl/pilot_pll_top.sv
module pilot_pll_top import pll_pkg::*; #(
  parameter longint unsigned CENTER_HZ = 19000,
  parameter longint unsigned SAMPLE_HZ = 240000,
  parameter int KP_MUL   = 37,
  parameter int KP_SHIFT = 2,
  parameter int KI_MUL   = 135,
  parameter int KI_SHIFT = 18,
  parameter int ACC_W    = 48,
  parameter int IDX_W    = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [SMP_W-1:0] in_sample,
  output logic                    out_valid,
  output logic [PH_W-1:0]         phase_o,
  output logic signed [SMP_W-1:0] err_o,
  output logic signed [SMP_W-1:0] cos1_o,
  output logic signed [SMP_W-1:0] cos2_o,
  output logic signed [SMP_W-1:0] cos3_o
);
  localparam phase_t STEP  = nominal_step(CENTER_HZ, SAMPLE_HZ);
  localparam int     N_HRM = 3;

  function automatic logic [IDX_W-1:0] harm_index(phase_t ph, int unsigned k);
    phase_t p;
    p = ph * phase_t'(k);
    return p[PH_W-1 -: IDX_W];
  endfunction

  phase_t  phase_q, phase_next;
  sample_t err_q, pd_err;
  logic    vld_q;
  logic signed [PH_W-1:0] ctrl;
  logic [IDX_W-1:0] hrm_idx [N_HRM];
  sample_t          hrm_cos [N_HRM];

  for (genvar h = 0; h < N_HRM; h++) begin : g_harm
    assign hrm_idx[h] = harm_index(phase_q, h + 1);
    pll_cos_lut #(.IDX_W(IDX_W)) u_lut (
      .idx_i (hrm_idx[h]),
      .cos_o (hrm_cos[h])
    );
  end

  pll_phase_det u_pd (
    .x_i   (in_sample),
    .cos_i (hrm_cos[0]),
    .err_o (pd_err)
  );

  pll_loop_filter #(
    .KP_MUL(KP_MUL), .KP_SHIFT(KP_SHIFT),
    .KI_MUL(KI_MUL), .KI_SHIFT(KI_SHIFT), .ACC_W(ACC_W)
  ) u_lf (
    .clk    (clk),
    .rst    (rst),
    .en_i   (in_valid),
    .err_i  (pd_err),
    .ctrl_o (ctrl)
  );

  assign phase_next = phase_q + STEP + phase_t'(ctrl);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      err_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        phase_q <= phase_next;
        err_q   <= pd_err;
      end
    end
  end

  assign out_valid = vld_q;
  assign phase_o   = phase_q;
  assign err_o     = err_q;
  assign cos1_o    = hrm_cos[0];
  assign cos2_o    = hrm_cos[1];
  assign cos3_o    = hrm_cos[2];

  // R1: state is clear in the cycle after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (phase_q == '0 && err_q == '0 && !vld_q));

  // R2: zero filter output gives exactly the nominal step
  assert_free_step_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctrl == '0) |=> phase_q == $past(phase_q) + STEP);

  // R3: no strobe, no change
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(phase_q) && $stable(err_q)));

  // R9: output strobe follows input strobe by one cycle
  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> vld_q);
  assert_valid_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !vld_q);
endmodule

// File: tb/sim_pilot_pll_top.sv
module sim_pilot_pll_top;
  localparam int  KP_MUL   = 148;
  localparam int  KP_SHIFT = 0;
  localparam int  KI_MUL   = 135;
  localparam int  KI_SHIFT = 10;
  localparam longint STEP_EXP = 340018244; // floor(2^32*19000/240000)
  localparam longint MASK32   = 64'hFFFF_FFFF;
  localparam real PI = 3.141592653589793;
  localparam int  NV = 12;
  localparam int  VX [NV] = '{10000, 0, 20000, -12000, 0, 31000, -32768, 32767, 7000, -3000, 0, 15000};
  localparam bit  VV [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_sample = '0;
  logic out_valid;
  logic [31:0] phase_o;
  logic signed [15:0] err_o, cos1_o, cos2_o, cos3_o;

  int  nchk = 0;
  int  nfail = 0;
  bit  done = 1'b0;
  longint ph_m, acc_m, err_m;

  always #5 clk = ~clk;

  pilot_pll_top #(
    .KP_MUL(KP_MUL), .KP_SHIFT(KP_SHIFT), .KI_MUL(KI_MUL), .KI_SHIFT(KI_SHIFT)
  ) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .phase_o(phase_o), .err_o(err_o),
    .cos1_o(cos1_o), .cos2_o(cos2_o), .cos3_o(cos3_o)
  );

  task automatic chk(string req, longint act, longint exp, longint tol);
    longint d;
    nchk++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      nfail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint cos_exp(longint ph);
    longint idx;
    real v;
    idx = (ph >> 22) & 1023;
    v = 32767.0 * $cos(2.0 * PI * (real'(idx) + 0.5) / 1024.0);
    if (v >= 0.0) return longint'($floor(v + 0.5));
    return -longint'($floor(-v + 0.5));
  endfunction

  task automatic check_cosines();
    longint p;
    p = longint'(phase_o);
    chk("R4 cos1", longint'(cos1_o), cos_exp(p), 1);
    chk("R5 cos2", longint'(cos2_o), cos_exp((p * 2) & MASK32), 1);
    chk("R5 cos3", longint'(cos3_o), cos_exp((p * 3) & MASK32), 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ph_m = 0; acc_m = 0; err_m = 0;
  endtask

  // one sample; caller is at a negedge
  task automatic step_sample(bit v, int x);
    longint c, ctrl;
    c = longint'(cos1_o);
    in_valid = v;
    in_sample = 16'(x);
    @(negedge clk);
    if (v) begin
      err_m = (longint'(x) * c) >>> 15;
      acc_m = acc_m + err_m * KI_MUL;
      ctrl  = ((err_m * KP_MUL) >>> KP_SHIFT) + (acc_m >>> KI_SHIFT);
      ph_m  = (ph_m + STEP_EXP + ctrl) & MASK32;
    end
    in_valid = 1'b0;
  endtask

  task automatic run_lock(real f_hz, real ph0, int nsettle, int nmeas);
    longint esum = 0;
    real maxd = 0.0;
    do_reset();
    for (int n = 0; n < nsettle + nmeas; n++) begin
      real psi, d;
      psi = 2.0 * PI * f_hz * real'(n) / 240000.0 + ph0;
      if (n >= nsettle) begin
        d = real'(phase_o) * 2.0 * PI / 4294967296.0 - psi;
        d = d - 2.0 * PI * $floor(d / (2.0 * PI) + 0.5);
        if (d < 0.0) d = -d;
        if (d > maxd) maxd = d;
        esum += longint'(err_o);
      end
      in_valid = 1'b1;
      in_sample = 16'($rtoi($floor(16384.0 * $sin(psi) + 0.5)));
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R8 mean error", esum / nmeas, 0, 300);
    chk("R8 phase tracking mrad", longint'(maxd * 1000.0), 0, 50);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 phase", longint'(phase_o), 0, 0);
    chk("R1 err", longint'(err_o), 0, 0);
    chk("R1 out_valid", longint'(out_valid), 0, 0);
    chk("R4 cos1 at zero", longint'(cos1_o), 32767, 0);

    // vector table walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      longint err_prev;
      err_prev = longint'(err_o);
      check_cosines();
      chk("R7 phase", longint'(phase_o), ph_m, 0);
      step_sample(VV[i], VX[i]);
      chk("R9 out_valid", longint'(out_valid), longint'(VV[i]), 0);
      if (VV[i]) chk("R6 err", longint'(err_o), err_m, 0);
      else       chk("R3 err held", longint'(err_o), err_prev, 0);
      chk("R3 R7 phase after", longint'(phase_o), ph_m, 0);
    end

    // R1: reset mid-run clears integrator; R2 exact step with zero input
    do_reset();
    step_sample(1'b1, 0);
    chk("R1 R2 step after reset", longint'(phase_o), STEP_EXP, 0);
    step_sample(1'b1, 0);
    chk("R2 second step", longint'(phase_o), (2 * STEP_EXP) & MASK32, 0);
    check_cosines();

    // R3: ignored sample leaves state unchanged
    step_sample(1'b0, 32767);
    chk("R3 phase held", longint'(phase_o), (2 * STEP_EXP) & MASK32, 0);
    chk("R3 out_valid low", longint'(out_valid), 0, 0);

    // R2: wrap modulo 2^32 across many free-running steps
    for (int k = 0; k < 20; k++) step_sample(1'b1, 0);
    chk("R2 wrap", longint'(phase_o), (22 * STEP_EXP) & MASK32, 0);
    check_cosines();

    // R8 lock above and below the centre
    run_lock(19003.0, 1.0, 20000, 2048);
    check_cosines();
    run_lock(18997.0, -2.0, 20000, 2048);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule